// File: doc/BRIEF.md
# On-chip Data RAM Access Router

This block sits on the external-data path of an 8-bit controller core. Every data-move access the core issues to its external data space passes through it. For each one the block decides whether the 2 KB on-chip data RAM serves it or the external bus does. The RAM occupies the top 2 KB of the 64 KB data space (F800h to FFFFh). The access address comes from one of two places. One is a 16-bit pointer. The other is an 8-bit register value, with the upper byte taken from a dedicated page register.

Software controls the RAM through two small registers on a special-function-register port: the page register and a control register. One control bit keeps the RAM switched off. It comes out of reset set. Software can clear it, and after that only a reset can set it again. A second control bit mirrors internal accesses onto the bus strobes, address and data for debugging. The RAM array lives inside the block and is never cleared by reset. A write takes two cycles. A reset that lands in the first cycle drops the write. A reset that lands in the second cycle lets the write complete.

Top module: `xdata_router`

## Requirements
- R1: After reset the page register reads 00h, the control register reads 01h (bit 0 = RAM off, bit 1 = debug mirror), and no bus request, RAM select or strobe enable is active.
- R2: Writing 0 to control bit 0 switches the RAM on. A later software write of 1 to that bit leaves it at 0. Only a reset sets it back to 1.
- R3: While control bit 0 is 1, every access is sent to the external bus and the RAM is never selected.
- R4: A pointer access (mx_ptr_mode = 1) with the RAM on uses the RAM exactly when the pointer's five top bits are all 1 (F800h or above). The RAM address is then pointer bits [10:0]. Lower pointers go to the bus with the full pointer.
- R5: A register access (mx_ptr_mode = 0) with the RAM on uses the RAM exactly when the page's top five bits are all 1 (page F8h or above). The RAM address is then {page[2:0], register}. Otherwise the bus address is {p2_latch, register}.
- R6: Every access not served by the RAM raises bus_req for exactly the cycle after the request, with bus_addr, bus_wr and, for writes, bus_wdata. An access served by the RAM raises no bus_req.
- R7: For a bus access, rd_strb_en or wr_strb_en follows the direction. For a RAM access both stay 0 when control bit 1 is 0. When bit 1 is 1 they follow the direction, and bus_addr shows the full address.
- R8: Control bit 1 does not change bus accesses, whether the RAM is off or the address lies outside the window.
- R9: A RAM write shows ram_we in the cycle after the request and commits at the end of that cycle. A later RAM read returns the stored byte on xr_rdata in the cycle after its request.
- R10: A reset asserted during the request cycle of a RAM write keeps the old byte. A reset asserted during the following cycle still writes the new byte.
- R11: RAM contents survive a reset.
- R12: The special-function-register port reads back the page as written (sfr_addr 0) and the control register (sfr_addr 1) with bits [7:2] reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 1 | Register select: 0 page, 1 control |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data (combinational) |
| mx_req | input | 1 | One-cycle access request from the core |
| mx_wr | input | 1 | Access direction, 1 = write |
| mx_ptr_mode | input | 1 | 1 = 16-bit pointer address, 0 = 8-bit register address |
| mx_ptr | input | 16 | Pointer address |
| mx_reg | input | 8 | Register address byte |
| mx_wdata | input | 8 | Write data |
| p2_latch | input | 8 | Port 2 latch, upper byte for external register accesses |
| xr_rdata | output | 8 | RAM read data, valid in the cycle after a RAM read request |
| ram_sel | output | 1 | RAM serves the access in this cycle |
| ram_addr | output | 11 | RAM word address |
| ram_we | output | 1 | RAM write commits at the end of this cycle |
| bus_req | output | 1 | One-cycle external access request |
| bus_wr | output | 1 | Direction of the bus access |
| bus_addr | output | 16 | Bus address (also the mirrored RAM address in debug mode) |
| bus_wdata | output | 8 | Bus write data (also mirrored RAM write data in debug mode) |
| rd_strb_en | output | 1 | Enable for the external read strobe |
| wr_strb_en | output | 1 | Enable for the external write strobe |

## Verification
On every cycle, the assertions check these properties: the off bit never rises without a reset, no access reaches the RAM while it is off, pointers and pages below the window never select the RAM, the RAM address tracks the pointer, a bus request and a RAM select never coexist, the strobes stay quiet for RAM accesses with mirroring off, and every bus request or RAM write follows a matching request. Only the bench scenarios can show the data path end to end. Those scenarios are: bytes written and read back through the array, survival of RAM contents across reset, the write kept or dropped depending on which cycle reset lands in, and the register readback values.

// File: rtl/xr_pkg.sv
`timescale 1ns/1ps
package xr_pkg;
  localparam int XR_AW     = 16;
  localparam int XR_DW     = 8;
  localparam int XR_RAM_AW = 11;

  // control register bit positions
  localparam int CTRL_OFF = 0;
  localparam int CTRL_DBG = 1;

  // register select codes on the SFR port
  localparam logic SFR_PAGE = 1'b0;
  localparam logic SFR_CTRL = 1'b1;

  typedef enum logic [1:0] {
    RT_IDLE = 2'd0,
    RT_RAM  = 2'd1,
    RT_BUS  = 2'd2
  } xr_route_e;
endpackage

// File: rtl/xr_rst_sync.sv
`timescale 1ns/1ps
module xr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ok = sync_q[1];
endmodule

// File: rtl/xr_sfr_regs.sv
`timescale 1ns/1ps
module xr_sfr_regs
  import xr_pkg::*;
#(
  parameter int DW = XR_DW
) (
  input  logic          clk,
  input  logic          rst_ok,
  input  logic          sfr_we,
  input  logic          sfr_addr,
  input  logic [DW-1:0] sfr_wdata,
  output logic [DW-1:0] sfr_rdata,
  output logic [DW-1:0] page_q,
  output logic          off_q,
  output logic          dbg_q
);
  logic [DW-1:0] page_d;
  logic          off_d;
  logic          dbg_d;

  // next state: the off bit can only be cleared by software
  always_comb begin
    page_d = page_q;
    off_d  = off_q;
    dbg_d  = dbg_q;
    if (sfr_we) begin
      if (sfr_addr == SFR_PAGE) begin
        page_d = sfr_wdata;
      end else begin
        off_d = off_q & sfr_wdata[CTRL_OFF];
        dbg_d = sfr_wdata[CTRL_DBG];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      page_q <= '0;
      off_q  <= 1'b1;
      dbg_q  <= 1'b0;
    end else begin
      page_q <= page_d;
      off_q  <= off_d;
      dbg_q  <= dbg_d;
    end
  end

  always_comb begin
    sfr_rdata = '0;
    if (sfr_addr == SFR_PAGE) begin
      sfr_rdata = page_q;
    end else begin
      sfr_rdata[CTRL_OFF] = off_q;
      sfr_rdata[CTRL_DBG] = dbg_q;
    end
  end
endmodule

// File: rtl/xr_decode.sv
`timescale 1ns/1ps
module xr_decode
  import xr_pkg::*;
#(
  parameter int AW     = XR_AW,
  parameter int DW     = XR_DW,
  parameter int RAM_AW = XR_RAM_AW
) (
  input  logic              req,
  input  logic              ptr_mode,
  input  logic [AW-1:0]     ptr,
  input  logic [DW-1:0]     regv,
  input  logic [AW-DW-1:0]  p2,
  input  logic [AW-DW-1:0]  page,
  input  logic              off,
  output xr_route_e         route,
  output logic [AW-1:0]     full_addr,
  output logic [RAM_AW-1:0] ram_addr
);
  localparam int PW     = AW - DW;
  localparam int PSEL_W = RAM_AW - DW;

  logic ptr_hit;
  logic page_hit;
  logic in_win;

  // the RAM is the topmost 2^RAM_AW bytes: all tag bits must be set
  assign ptr_hit  = &ptr[AW-1:RAM_AW];
  assign page_hit = &page[PW-1:PSEL_W];

  always_comb begin
    if (ptr_mode) begin
      in_win    = ptr_hit;
      full_addr = ptr;
      ram_addr  = ptr[RAM_AW-1:0];
    end else begin
      in_win    = page_hit;
      full_addr = page_hit ? {page, regv} : {p2, regv};
      ram_addr  = {page[PSEL_W-1:0], regv};
    end
  end

  always_comb begin
    if (!req)                 route = RT_IDLE;
    else if (in_win && !off)  route = RT_RAM;
    else                      route = RT_BUS;
  end
endmodule

// File: rtl/xr_stage.sv
`timescale 1ns/1ps
module xr_stage
  import xr_pkg::*;
#(
  parameter int AW     = XR_AW,
  parameter int DW     = XR_DW,
  parameter int RAM_AW = XR_RAM_AW
) (
  input  logic              clk,
  input  logic              rst_ok,
  input  xr_route_e         route,
  input  logic              wr,
  input  logic [AW-1:0]     full_addr,
  input  logic [RAM_AW-1:0] ram_addr_in,
  input  logic [DW-1:0]     wdata,
  input  logic              dbg,
  output logic              ram_sel,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DW-1:0]     ram_wdata,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic              rd_strb_en,
  output logic              wr_strb_en
);
  // commit stage: not cleared by reset so that a write accepted in the
  // request cycle still lands when reset arrives in the second cycle
  logic              cm_vld_q, cm_vld_d;
  logic              cm_wr_q,  cm_wr_d;
  logic              cm_dbg_q, cm_dbg_d;
  logic [RAM_AW-1:0] cm_addr_q, cm_addr_d;
  logic [AW-1:0]     cm_full_q, cm_full_d;
  logic [DW-1:0]     cm_wdata_q, cm_wdata_d;

  // bus stage: cleared by reset
  logic              bq_req_q, bq_req_d;
  logic              bq_wr_q, bq_wr_d;
  logic [AW-1:0]     bq_addr_q, bq_addr_d;
  logic [DW-1:0]     bq_wdata_q, bq_wdata_d;

  logic              cm_load;
  logic              bq_load;
  logic              mirror;

  assign cm_load = (route == RT_RAM);
  assign bq_load = (route == RT_BUS);

  always_comb begin
    cm_vld_d   = cm_load & rst_ok;
    cm_wr_d    = cm_wr_q;
    cm_dbg_d   = cm_dbg_q;
    cm_addr_d  = cm_addr_q;
    cm_full_d  = cm_full_q;
    cm_wdata_d = cm_wdata_q;
    if (cm_load) begin
      cm_wr_d    = wr;
      cm_dbg_d   = dbg;
      cm_addr_d  = ram_addr_in;
      cm_full_d  = full_addr;
      cm_wdata_d = wdata;
    end
  end

  always_ff @(posedge clk) begin
    cm_vld_q   <= cm_vld_d;
    cm_wr_q    <= cm_wr_d;
    cm_dbg_q   <= cm_dbg_d;
    cm_addr_q  <= cm_addr_d;
    cm_full_q  <= cm_full_d;
    cm_wdata_q <= cm_wdata_d;
  end

  always_comb begin
    bq_req_d   = bq_load;
    bq_wr_d    = bq_wr_q;
    bq_addr_d  = bq_addr_q;
    bq_wdata_d = bq_wdata_q;
    if (bq_load) begin
      bq_wr_d    = wr;
      bq_addr_d  = full_addr;
      bq_wdata_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      bq_req_q   <= 1'b0;
      bq_wr_q    <= 1'b0;
      bq_addr_q  <= '0;
      bq_wdata_q <= '0;
    end else begin
      bq_req_q   <= bq_req_d;
      bq_wr_q    <= bq_wr_d;
      bq_addr_q  <= bq_addr_d;
      bq_wdata_q <= bq_wdata_d;
    end
  end

  assign mirror     = cm_vld_q & cm_dbg_q;
  assign ram_sel    = cm_vld_q;
  assign ram_we     = cm_vld_q & cm_wr_q;
  assign ram_addr   = cm_addr_q;
  assign ram_wdata  = cm_wdata_q;
  assign bus_req    = bq_req_q;
  assign bus_wr     = mirror ? cm_wr_q    : bq_wr_q;
  assign bus_addr   = mirror ? cm_full_q  : bq_addr_q;
  assign bus_wdata  = mirror ? cm_wdata_q : bq_wdata_q;
  assign rd_strb_en = (bq_req_q & ~bq_wr_q) | (mirror & ~cm_wr_q);
  assign wr_strb_en = (bq_req_q &  bq_wr_q) | (mirror &  cm_wr_q);
endmodule

// File: rtl/xr_array.sv
`timescale 1ns/1ps
module xr_array #(
  parameter int DW     = 8,
  parameter int RAM_AW = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RAM_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << RAM_AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/xdata_router.sv
`timescale 1ns/1ps
module xdata_router
  import xr_pkg::*;
#(
  parameter int AW     = XR_AW,
  parameter int DW     = XR_DW,
  parameter int RAM_AW = XR_RAM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_we,
  input  logic              sfr_addr,
  input  logic [DW-1:0]     sfr_wdata,
  output logic [DW-1:0]     sfr_rdata,
  input  logic              mx_req,
  input  logic              mx_wr,
  input  logic              mx_ptr_mode,
  input  logic [AW-1:0]     mx_ptr,
  input  logic [DW-1:0]     mx_reg,
  input  logic [DW-1:0]     mx_wdata,
  input  logic [AW-DW-1:0]  p2_latch,
  output logic [DW-1:0]     xr_rdata,
  output logic              ram_sel,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic              rd_strb_en,
  output logic              wr_strb_en
);
  logic              rst_ok;
  logic [AW-DW-1:0]  page_q;
  logic              off_q;
  logic              dbg_q;
  xr_route_e         route;
  logic [AW-1:0]     dec_full;
  logic [RAM_AW-1:0] dec_ram_addr;
  logic [DW-1:0]     ram_wdata;

  xr_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  xr_sfr_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_ok    (rst_ok),
    .sfr_we    (sfr_we),
    .sfr_addr  (sfr_addr),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata),
    .page_q    (page_q),
    .off_q     (off_q),
    .dbg_q     (dbg_q)
  );

  xr_decode #(.AW(AW), .DW(DW), .RAM_AW(RAM_AW)) u_dec (
    .req       (mx_req),
    .ptr_mode  (mx_ptr_mode),
    .ptr       (mx_ptr),
    .regv      (mx_reg),
    .p2        (p2_latch),
    .page      (page_q),
    .off       (off_q),
    .route     (route),
    .full_addr (dec_full),
    .ram_addr  (dec_ram_addr)
  );

  xr_stage #(.AW(AW), .DW(DW), .RAM_AW(RAM_AW)) u_stage (
    .clk         (clk),
    .rst_ok      (rst_ok),
    .route       (route),
    .wr          (mx_wr),
    .full_addr   (dec_full),
    .ram_addr_in (dec_ram_addr),
    .wdata       (mx_wdata),
    .dbg         (dbg_q),
    .ram_sel     (ram_sel),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_wdata   (ram_wdata),
    .bus_req     (bus_req),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .rd_strb_en  (rd_strb_en),
    .wr_strb_en  (wr_strb_en)
  );

  xr_array #(.DW(DW), .RAM_AW(RAM_AW)) u_mem (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (xr_rdata)
  );
endmodule

// File: rtl/xdata_router_chk.sv
`timescale 1ns/1ps
module xdata_router_chk #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int RAM_AW = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mx_req,
  input logic              mx_wr,
  input logic              mx_ptr_mode,
  input logic [AW-1:0]     mx_ptr,
  input logic [AW-DW-1:0]  page_q,
  input logic              off_q,
  input logic              dbg_q,
  input logic              ram_sel,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_we,
  input logic              bus_req,
  input logic              rd_strb_en,
  input logic              wr_strb_en
);
  localparam int PW     = AW - DW;
  localparam int PSEL_W = RAM_AW - DW;

  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !off_q |=> !off_q); // R2

  AST_OFF_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    mx_req && off_q |=> !ram_sel); // R3

  AST_PTR_LOW_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    mx_req && mx_ptr_mode && !(&mx_ptr[AW-1:RAM_AW]) |=> !ram_sel); // R4

  AST_PTR_RAM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mx_req && mx_ptr_mode && !off_q && (&mx_ptr[AW-1:RAM_AW])
      |=> ram_sel && (ram_addr == $past(mx_ptr[RAM_AW-1:0]))); // R4

  AST_PAGE_LOW_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    mx_req && !mx_ptr_mode && !(&page_q[PW-1:PSEL_W]) |=> !ram_sel); // R5

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && ram_sel)); // R6

  AST_BUSREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> $past(mx_req)); // R6

  AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_strb_en, wr_strb_en})); // R7

  AST_STRB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel && !$past(dbg_q) |-> !rd_strb_en && !wr_strb_en); // R7

  AST_WE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(mx_req && mx_wr)); // R9
endmodule

bind xdata_router xdata_router_chk #(.AW(AW), .DW(DW), .RAM_AW(RAM_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mx_req      (mx_req),
  .mx_wr       (mx_wr),
  .mx_ptr_mode (mx_ptr_mode),
  .mx_ptr      (mx_ptr),
  .page_q      (page_q),
  .off_q       (off_q),
  .dbg_q       (dbg_q),
  .ram_sel     (ram_sel),
  .ram_addr    (ram_addr),
  .ram_we      (ram_we),
  .bus_req     (bus_req),
  .rd_strb_en  (rd_strb_en),
  .wr_strb_en  (wr_strb_en)
);

// File: tb/xdata_router_tb.sv
`timescale 1ns/1ps
module xdata_router_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sfr_we, sfr_addr;
  logic [7:0]  sfr_wdata, sfr_rdata;
  logic        mx_req, mx_wr, mx_ptr_mode;
  logic [15:0] mx_ptr;
  logic [7:0]  mx_reg, mx_wdata, p2_latch, xr_rdata;
  logic        ram_sel, ram_we, bus_req, bus_wr, rd_strb_en, wr_strb_en;
  logic [10:0] ram_addr;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] ref_mem   [2048];
  bit         ref_known [2048];
  logic [7:0] m_page;
  bit         m_off, m_dbg;

  always #4 clk = ~clk;

  xdata_router u_dut (
    .clk(clk), .rst_n(rst_n),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .mx_req(mx_req), .mx_wr(mx_wr), .mx_ptr_mode(mx_ptr_mode), .mx_ptr(mx_ptr),
    .mx_reg(mx_reg), .mx_wdata(mx_wdata), .p2_latch(p2_latch), .xr_rdata(xr_rdata),
    .ram_sel(ram_sel), .ram_addr(ram_addr), .ram_we(ram_we),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_strb_en(rd_strb_en), .wr_strb_en(wr_strb_en)
  );

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic bit exp_hit(input bit pm, input logic [15:0] ptr, input logic [7:0] pg);
    return pm ? (&ptr[15:11]) : (&pg[7:3]);
  endfunction

  function automatic logic [15:0] exp_full(input bit pm, input logic [15:0] ptr,
                                           input logic [7:0] rg, input logic [7:0] p2,
                                           input logic [7:0] pg);
    if (pm) return ptr;
    return (&pg[7:3]) ? {pg, rg} : {p2, rg};
  endfunction

  function automatic logic [10:0] exp_raddr(input bit pm, input logic [15:0] ptr,
                                            input logic [7:0] rg, input logic [7:0] pg);
    return pm ? ptr[10:0] : {pg[2:0], rg};
  endfunction

  task automatic model_reset();
    m_page = 8'h00; m_off = 1'b1; m_dbg = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  task automatic sfr_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
    if (a == 1'b0) m_page = d;
    else begin m_off = m_off & d[0]; m_dbg = d[1]; end
  endtask

  task automatic sfr_rd(input logic a, input logic [7:0] exp, input string rq);
    @(negedge clk);
    sfr_addr = a;
    #1;
    check(rq, a ? "ctrl readback" : "page readback", sfr_rdata, exp);
  endtask

  task automatic drive_req(input bit pm, input bit wr, input logic [15:0] ptr,
                           input logic [7:0] rg, input logic [7:0] p2, input logic [7:0] wd);
    mx_req = 1'b1; mx_wr = wr; mx_ptr_mode = pm; mx_ptr = ptr;
    mx_reg = rg; p2_latch = p2; mx_wdata = wd;
  endtask

  task automatic movx(input bit pm, input bit wr, input logic [15:0] ptr,
                      input logic [7:0] rg, input logic [7:0] p2, input logic [7:0] wd,
                      input string dtag = "R9");
    bit          inr;
    logic [15:0] full;
    logic [10:0] ra;
    string       rq, sq;
    inr  = exp_hit(pm, ptr, m_page) && !m_off;
    full = exp_full(pm, ptr, rg, p2, m_page);
    ra   = exp_raddr(pm, ptr, rg, m_page);
    rq   = m_off ? "R3" : (pm ? "R4" : "R5");
    sq   = m_dbg ? "R8" : "R7";
    @(negedge clk);
    drive_req(pm, wr, ptr, rg, p2, wd);
    @(negedge clk);
    mx_req = 1'b0;
    check(rq, "ram_sel", ram_sel, inr);
    check("R6", "bus_req", bus_req, !inr);
    if (inr) begin
      check(rq, "ram_addr", ram_addr, ra);
      check("R9", "ram_we", ram_we, wr);
      check("R7", "rd_strb ram", rd_strb_en, m_dbg && !wr);
      check("R7", "wr_strb ram", wr_strb_en, m_dbg && wr);
      if (m_dbg) check("R7", "mirror addr", bus_addr, full);
      if (!wr && ref_known[ra]) check(dtag, "rdata", xr_rdata, ref_mem[ra]);
      if (wr) begin ref_mem[ra] = wd; ref_known[ra] = 1'b1; end
    end else begin
      check(rq, "bus_addr", bus_addr, full);
      check("R6", "bus_wr", bus_wr, wr);
      check(sq, "rd_strb bus", rd_strb_en, !wr);
      check(sq, "wr_strb bus", wr_strb_en, wr);
      if (wr) check("R6", "bus_wdata", bus_wdata, wd);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0; sfr_we = 1'b0; sfr_addr = 1'b0; sfr_wdata = '0;
    mx_req = 1'b0; mx_wr = 1'b0; mx_ptr_mode = 1'b0; mx_ptr = '0;
    mx_reg = '0; mx_wdata = '0; p2_latch = '0;
    for (int i = 0; i < 2048; i++) ref_known[i] = 1'b0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1", "bus_req idle", bus_req, 1'b0);
    check("R1", "ram_sel idle", ram_sel, 1'b0);
    check("R1", "strobes idle", {rd_strb_en, wr_strb_en}, 2'b00);
    sfr_rd(1'b0, 8'h00, "R1");
    sfr_rd(1'b1, 8'h01, "R1");

    // R3 window access while off, also with mirror bit set (R8)
    movx(1'b1, 1'b1, 16'hF900, 8'h00, 8'h00, 8'h11);
    sfr_wr(1'b1, 8'h03);
    sfr_rd(1'b1, 8'h03, "R12");
    movx(1'b1, 1'b0, 16'hFFFF, 8'h00, 8'h00, 8'h00);

    // R12 readback, unused control bits read 0
    sfr_wr(1'b0, 8'hA5);
    sfr_rd(1'b0, 8'hA5, "R12");
    sfr_wr(1'b1, 8'hFD);
    sfr_rd(1'b1, 8'h01, "R12");

    // R2 clear the off bit, try to set it again
    sfr_wr(1'b1, 8'h00);
    sfr_rd(1'b1, 8'h00, "R2");
    sfr_wr(1'b1, 8'h01);
    sfr_rd(1'b1, 8'h00, "R2");

    // R4 boundary pointers
    movx(1'b1, 1'b1, 16'hF800, 8'h00, 8'h00, 8'h5C);
    movx(1'b1, 1'b1, 16'hF7FF, 8'h00, 8'h00, 8'h77);
    movx(1'b1, 1'b1, 16'hFFFF, 8'h00, 8'h00, 8'hE1);
    movx(1'b1, 1'b0, 16'hF800, 8'h00, 8'h00, 8'h00);
    movx(1'b1, 1'b0, 16'hFFFF, 8'h00, 8'h00, 8'h00);

    // R5 page boundary and port 2 substitution
    sfr_wr(1'b0, 8'hF7);
    movx(1'b0, 1'b0, 16'h0000, 8'h3E, 8'h12, 8'h00);
    sfr_wr(1'b0, 8'hF8);
    movx(1'b0, 1'b1, 16'h0000, 8'h00, 8'h12, 8'h9B);
    movx(1'b1, 1'b0, 16'hF800, 8'h00, 8'h00, 8'h00);

    // R7 mirror of RAM accesses onto the bus, R8 no effect on bus accesses
    sfr_wr(1'b1, 8'h02);
    movx(1'b0, 1'b1, 16'h0000, 8'h44, 8'h00, 8'h6D);
    movx(1'b0, 1'b0, 16'h0000, 8'h44, 8'h00, 8'h00);
    movx(1'b1, 1'b1, 16'h1234, 8'h00, 8'h00, 8'h2A);
    sfr_wr(1'b1, 8'h00);

    // R10 reset in the request cycle drops the write
    movx(1'b1, 1'b1, 16'hFA10, 8'h00, 8'h00, 8'h3C);
    @(negedge clk);
    drive_req(1'b1, 1'b1, 16'hFA10, 8'h00, 8'h00, 8'hC3);
    #1 rst_n = 1'b0;
    @(negedge clk);
    mx_req = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    sfr_rd(1'b1, 8'h01, "R2");
    sfr_wr(1'b1, 8'h00);
    movx(1'b1, 1'b0, 16'hFA10, 8'h00, 8'h00, 8'h00, "R10");

    // R10 reset in the second cycle still commits
    @(negedge clk);
    drive_req(1'b1, 1'b1, 16'hFA10, 8'h00, 8'h00, 8'h5A);
    @(negedge clk);
    mx_req = 1'b0;
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    ref_mem[11'h210] = 8'h5A;
    sfr_wr(1'b1, 8'h00);
    movx(1'b1, 1'b0, 16'hFA10, 8'h00, 8'h00, 8'h00, "R10");

    // R11 contents survive a plain reset
    do_reset();
    sfr_wr(1'b1, 8'h00);
    movx(1'b1, 1'b0, 16'hF800, 8'h00, 8'h00, 8'h00, "R11");
    movx(1'b1, 1'b0, 16'hFFFF, 8'h00, 8'h00, 8'h00, "R11");

    // constrained random mix
    for (int i = 0; i < 500; i++) begin
      int unsigned k;
      logic [15:0] p;
      logic [7:0]  pg;
      k = $urandom_range(0, 11);
      if (k == 0) begin
        pg = $urandom_range(0, 1) ? (8'hF8 | 8'($urandom_range(0, 7))) : 8'($urandom());
        sfr_wr(1'b0, pg);
      end else if (k == 1) begin
        sfr_wr(1'b1, 8'($urandom_range(0, 3)));
      end else begin
        p = $urandom_range(0, 2) != 0 ? (16'hF800 | 16'($urandom_range(0, 2047)))
                                      : 16'($urandom());
        movx(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), p,
             8'($urandom()), 8'($urandom()), 8'($urandom()));
      end
    end

    done = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule